// File: doc/BRIEF.md
# Register Stack Frame Marker Unit

This block holds the descriptor of the active window in a stacked general-register file, together with the copy saved when a procedure call happens. The descriptor gives the total window size, the part reserved for locals, the size of the rotating region (in groups of eight registers) and three rename bases, one each for general, floating-point and predicate rotation. Nothing outside the block writes the descriptor directly. It changes only in response to three request strobes: allocate, call and return.

An allocate request installs a new window layout after a legality check. A call saves the whole current descriptor and opens a callee window made only of the caller's output registers. A return puts the saved descriptor back. The block also reports two counts taken from the live descriptor: the number of output registers and the number of rotating registers. Spill and fill traffic, the register array and the rotation renaming path belong to other blocks.

Top module: `fmu_top`

## Requirements
- R1: While reset is low, and after it is released, both descriptors read zero and the error flag reads zero.
- R2: Each descriptor is 38 bits wide and packed from bit 0 upward: window size [6:0], locals size [13:7], rotating size [17:14], general rename base [24:18], floating-point rename base [31:25], predicate rename base [37:32].
- R3: An accepted allocate writes window, locals and rotating sizes into the current descriptor, keeps its rename bases, and leaves the saved descriptor unchanged. Locals equal to the window size is accepted.
- R4: An allocate is rejected when locals exceed the window size, when eight times the rotating size exceeds the window size, or when the window size exceeds 96. A rejected allocate leaves both descriptors unchanged and raises the error flag for exactly the next cycle.
- R5: A call copies the whole current descriptor into the saved descriptor.
- R6: After a call, the current descriptor has window size equal to the caller's window size minus the caller's locals size. Its locals size, rotating size and all three rename bases are zero.
- R7: A return loads the current descriptor from the saved descriptor and leaves the saved descriptor unchanged.
- R8: The output-register count equals the current window size minus the current locals size. The rotating-register count equals eight times the current rotating size.
- R9: When more than one request strobe is high in the same cycle, neither descriptor changes and the error flag is raised for the next cycle.
- R10: In a cycle with no request, both descriptors hold their values and the error flag reads zero on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Allocate request strobe |
| call_req | input | 1 | Call request strobe |
| ret_req | input | 1 | Return request strobe |
| alloc_frm | input | 7 | Requested window size |
| alloc_loc | input | 7 | Requested locals size |
| alloc_rot | input | 4 | Requested rotating size, in groups of eight |
| cur_marker | output | 38 | Current descriptor, packed |
| prev_marker | output | 38 | Saved descriptor, packed |
| out_regs | output | 7 | Output-register count of the current window |
| rot_regs | output | 7 | Rotating-register count of the current window |
| alloc_err | output | 1 | One-cycle flag for a rejected or conflicting request |

## Verification
Every request is sampled on one rising edge. Both descriptors and the error flag show the result right after that edge, so each result is due one cycle after the request. The two counts come combinationally from the current descriptor, so they update in that same cycle. The bench drives each request on a falling edge and samples all outputs on the next falling edge, exactly one rising edge later. Before that edge the strobes are changed only on falling edges. The reset check samples while reset is held low and again after it is released.

// File: rtl/fmu_pkg.sv
// Package: field widths, the packed descriptor type and the request decode
// type shared by every module of the frame marker unit.
// Assumes the descriptor layout is fixed by the consumers that decode it.
package fmu_pkg;

    localparam int FS_W      = 7;   // window size field width
    localparam int LS_W      = 7;   // locals size field width
    localparam int RS_W      = 4;   // rotating size field width (groups)
    localparam int GB_W      = 7;   // general rename base width
    localparam int FB_W      = 7;   // floating-point rename base width
    localparam int PB_W      = 6;   // predicate rename base width
    localparam int ROT_SHIFT = 3;   // one rotating group is 2**ROT_SHIFT registers
    localparam int MARK_W    = FS_W + LS_W + RS_W + GB_W + FB_W + PB_W;
    localparam int ROTC_W    = RS_W + ROT_SHIFT;

    // Packed so that window size sits at the least significant end.
    typedef struct packed {
        logic [PB_W-1:0] pr_base;
        logic [FB_W-1:0] fr_base;
        logic [GB_W-1:0] gr_base;
        logic [RS_W-1:0] rot_sz;
        logic [LS_W-1:0] loc_sz;
        logic [FS_W-1:0] frm_sz;
    } fmark_t;

    typedef enum logic [2:0] {
        FOP_IDLE     = 3'd0,
        FOP_ALLOC    = 3'd1,
        FOP_CALL     = 3'd2,
        FOP_RET      = 3'd3,
        FOP_CONFLICT = 3'd4
    } fop_e;

endpackage

// File: rtl/fmu_decode.sv
// Request decoder: turns the three request strobes into one operation code.
// Assumes strobes are single-cycle and that any overlap is a caller fault,
// which is reported as a conflict rather than resolved by priority.
module fmu_decode
    import fmu_pkg::*;
(
    input  logic alloc_req,
    input  logic call_req,
    input  logic ret_req,
    output fop_e op
);

    logic [1:0] n_req;

    // Count active strobes so overlaps can be detected.
    always_comb begin
        n_req = 2'(alloc_req) + 2'(call_req) + 2'(ret_req);
    end

    // Select the operation, treating two or more strobes as a conflict.
    always_comb begin
        if (n_req > 2'd1) begin
            op = FOP_CONFLICT;
        end else if (alloc_req) begin
            op = FOP_ALLOC;
        end else if (call_req) begin
            op = FOP_CALL;
        end else if (ret_req) begin
            op = FOP_RET;
        end else begin
            op = FOP_IDLE;
        end
    end

endmodule

// File: rtl/fmu_alloc_check.sv
// Allocation legality check: a requested layout is legal when locals and the
// rotating region each fit in the window and the window fits the stack limit.
// Assumes MAX_FRAME is representable in the window size field.
module fmu_alloc_check
    import fmu_pkg::*;
#(
    parameter int MAX_FRAME = 96
) (
    input  logic [FS_W-1:0] req_frm,
    input  logic [LS_W-1:0] req_loc,
    input  logic [RS_W-1:0] req_rot,
    output logic            legal
);

    localparam int CMP_W = (FS_W > ROTC_W ? FS_W : ROTC_W) + 1;
    localparam logic [CMP_W-1:0] MAXF = CMP_W'(MAX_FRAME);

    logic [CMP_W-1:0] frm_w;
    logic [CMP_W-1:0] loc_w;
    logic [CMP_W-1:0] rot_w;
    logic             loc_ok;
    logic             rot_ok;
    logic             max_ok;

    // Widen all operands to one comparison width.
    always_comb begin
        frm_w = CMP_W'(req_frm);
        loc_w = CMP_W'(req_loc);
        rot_w = CMP_W'(req_rot) << ROT_SHIFT;
    end

    // Evaluate the three fit conditions independently.
    always_comb begin
        loc_ok = (loc_w <= frm_w);
        rot_ok = (rot_w <= frm_w);
        max_ok = (frm_w <= MAXF);
        legal  = loc_ok & rot_ok & max_ok;
    end

endmodule

// File: rtl/fmu_next.sv
// Next-state logic: computes the next current and saved descriptors and the
// error flag from the decoded operation and the allocation check result.
// Assumes the current descriptor always has locals no larger than the window,
// which every accepted operation preserves.
module fmu_next
    import fmu_pkg::*;
(
    input  fop_e            op,
    input  logic            legal,
    input  logic [FS_W-1:0] req_frm,
    input  logic [LS_W-1:0] req_loc,
    input  logic [RS_W-1:0] req_rot,
    input  fmark_t          cur,
    input  fmark_t          prev,
    output fmark_t          nxt_cur,
    output fmark_t          nxt_prev,
    output logic            nxt_err
);

    fmark_t callee;
    fmark_t alloced;

    // Build the callee window: caller outputs only, every other field cleared.
    always_comb begin
        callee        = '0;
        callee.frm_sz = cur.frm_sz - FS_W'(cur.loc_sz);
    end

    // Build the allocated layout, keeping the live rename bases.
    always_comb begin
        alloced        = cur;
        alloced.frm_sz = req_frm;
        alloced.loc_sz = req_loc;
        alloced.rot_sz = req_rot;
    end

    // Choose the next register contents from the operation.
    always_comb begin
        nxt_cur  = cur;
        nxt_prev = prev;
        nxt_err  = 1'b0;
        unique case (op)
            FOP_ALLOC: begin
                if (legal) begin
                    nxt_cur = alloced;
                end else begin
                    nxt_err = 1'b1;
                end
            end
            FOP_CALL: begin
                nxt_prev = cur;
                nxt_cur  = callee;
            end
            FOP_RET: begin
                nxt_cur = prev;
            end
            FOP_CONFLICT: begin
                nxt_err = 1'b1;
            end
            default: begin
                nxt_cur  = cur;
                nxt_prev = prev;
            end
        endcase
    end

endmodule

// File: rtl/fmu_top.sv
// Frame marker unit top: holds the current and saved descriptors of the
// stacked register window and applies allocate, call and return requests.
// Assumes one request per cycle; overlapping requests are flagged and ignored.
// Both descriptors clear on a synchronous active-low reset.
module fmu_top
    import fmu_pkg::*;
#(
    parameter int MAX_FRAME = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic              call_req,
    input  logic              ret_req,
    input  logic [FS_W-1:0]   alloc_frm,
    input  logic [LS_W-1:0]   alloc_loc,
    input  logic [RS_W-1:0]   alloc_rot,
    output logic [MARK_W-1:0] cur_marker,
    output logic [MARK_W-1:0] prev_marker,
    output logic [FS_W-1:0]   out_regs,
    output logic [ROTC_W-1:0] rot_regs,
    output logic              alloc_err
);

    fop_e   op;
    logic   legal;
    fmark_t cur_q;
    fmark_t prev_q;
    fmark_t cur_d;
    fmark_t prev_d;
    logic   err_d;
    logic   err_q;

    fmu_decode u_decode (
        .alloc_req (alloc_req),
        .call_req  (call_req),
        .ret_req   (ret_req),
        .op        (op)
    );

    fmu_alloc_check #(
        .MAX_FRAME (MAX_FRAME)
    ) u_check (
        .req_frm (alloc_frm),
        .req_loc (alloc_loc),
        .req_rot (alloc_rot),
        .legal   (legal)
    );

    fmu_next u_next (
        .op       (op),
        .legal    (legal),
        .req_frm  (alloc_frm),
        .req_loc  (alloc_loc),
        .req_rot  (alloc_rot),
        .cur      (cur_q),
        .prev     (prev_q),
        .nxt_cur  (cur_d),
        .nxt_prev (prev_d),
        .nxt_err  (err_d)
    );

    // Hold both descriptors and the error pulse; reset clears all of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            prev_q <= '0;
            err_q  <= 1'b0;
        end else begin
            cur_q  <= cur_d;
            prev_q <= prev_d;
            err_q  <= err_d;
        end
    end

    // Drive the packed descriptors and the derived counts.
    always_comb begin
        cur_marker  = cur_q;
        prev_marker = prev_q;
        alloc_err   = err_q;
        out_regs    = cur_q.frm_sz - FS_W'(cur_q.loc_sz);
        rot_regs    = ROTC_W'(cur_q.rot_sz) << ROT_SHIFT;
    end

endmodule

// File: rtl/fmu_chk.sv
// Checker for the frame marker unit, bound to every fmu_top instance.
// Relates requests to descriptor changes one cycle later.
module fmu_chk
    import fmu_pkg::*;
#(
    parameter int MAX_FRAME = 96
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_req,
    input logic              call_req,
    input logic              ret_req,
    input logic [FS_W-1:0]   alloc_frm,
    input logic [LS_W-1:0]   alloc_loc,
    input logic [RS_W-1:0]   alloc_rot,
    input logic [MARK_W-1:0] cur_marker,
    input logic [MARK_W-1:0] prev_marker,
    input logic [FS_W-1:0]   out_regs,
    input logic              alloc_err
);

    fmark_t c_m;
    fmark_t p_m;
    logic   only_alloc;
    logic   only_call;
    logic   only_ret;
    logic   none_req;
    logic   bad_req;
    logic   many_req;

    // Decode the request pattern and the allocation fit independently.
    always_comb begin
        c_m        = cur_marker;
        p_m        = prev_marker;
        only_alloc = alloc_req && !call_req && !ret_req;
        only_call  = call_req && !alloc_req && !ret_req;
        only_ret   = ret_req && !alloc_req && !call_req;
        none_req   = !alloc_req && !call_req && !ret_req;
        many_req   = $countones({alloc_req, call_req, ret_req}) > 1;
        bad_req    = (32'(alloc_loc) > 32'(alloc_frm))
                  || ((32'(alloc_rot) * 8) > 32'(alloc_frm))
                  || (32'(alloc_frm) > MAX_FRAME);
    end

    // R4
    bad_alloc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        only_alloc && bad_req |=> alloc_err && $stable(cur_marker) && $stable(prev_marker));

    // R5
    call_saves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        only_call |=> prev_marker == $past(cur_marker));

    // R6
    call_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        only_call |=> cur_marker[MARK_W-1:FS_W] == '0
                   && c_m.frm_sz == $past(c_m.frm_sz - FS_W'(c_m.loc_sz)));

    // R7
    ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        only_ret |=> cur_marker == $past(prev_marker) && $stable(prev_marker));

    // R8
    out_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_regs <= c_m.frm_sz);

    // R9
    conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        many_req |=> alloc_err && $stable(cur_marker) && $stable(prev_marker));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        none_req |=> !alloc_err && $stable(cur_marker) && $stable(prev_marker));

    // R3
    alloc_keeps_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        only_alloc |=> $stable(prev_marker));

endmodule

bind fmu_top fmu_chk #(
    .MAX_FRAME (MAX_FRAME)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_req   (alloc_req),
    .call_req    (call_req),
    .ret_req     (ret_req),
    .alloc_frm   (alloc_frm),
    .alloc_loc   (alloc_loc),
    .alloc_rot   (alloc_rot),
    .cur_marker  (cur_marker),
    .prev_marker (prev_marker),
    .out_regs    (out_regs),
    .alloc_err   (alloc_err)
);

// File: tb/sim_fmu_top.sv
`timescale 1ns/1ps
module sim_fmu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_req = 1'b0;
    logic        call_req = 1'b0;
    logic        ret_req = 1'b0;
    logic [6:0]  alloc_frm = '0;
    logic [6:0]  alloc_loc = '0;
    logic [3:0]  alloc_rot = '0;
    logic [37:0] cur_marker;
    logic [37:0] prev_marker;
    logic [6:0]  out_regs;
    logic [6:0]  rot_regs;
    logic        alloc_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    fmu_top u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_req   (alloc_req),
        .call_req    (call_req),
        .ret_req     (ret_req),
        .alloc_frm   (alloc_frm),
        .alloc_loc   (alloc_loc),
        .alloc_rot   (alloc_rot),
        .cur_marker  (cur_marker),
        .prev_marker (prev_marker),
        .out_regs    (out_regs),
        .rot_regs    (rot_regs),
        .alloc_err   (alloc_err)
    );

    always #2 clk = ~clk;

    // Operation bits: [2] allocate, [1] call, [0] return.
    typedef struct packed {
        logic [2:0] op;
        logic [6:0] fs;
        logic [6:0] ls;
        logic [3:0] rs;
        logic [6:0] c_fs;
        logic [6:0] c_ls;
        logic [3:0] c_rs;
        logic [6:0] p_fs;
        logic [6:0] p_ls;
        logic [3:0] p_rs;
        logic       err;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{3'b100, 7'd20, 7'd5,  4'd1,  7'd20, 7'd5, 4'd1,  7'd0,  7'd0, 4'd0, 1'b0, 4'd3},  // R3
        '{3'b100, 7'd10, 7'd12, 4'd0,  7'd20, 7'd5, 4'd1,  7'd0,  7'd0, 4'd0, 1'b1, 4'd4},  // R4 locals too big
        '{3'b010, 7'd0,  7'd0,  4'd0,  7'd15, 7'd0, 4'd0,  7'd20, 7'd5, 4'd1, 1'b0, 4'd6},  // R6 and R5
        '{3'b100, 7'd40, 7'd8,  4'd2,  7'd40, 7'd8, 4'd2,  7'd20, 7'd5, 4'd1, 1'b0, 4'd3},  // R3
        '{3'b100, 7'd96, 7'd0,  4'd12, 7'd96, 7'd0, 4'd12, 7'd20, 7'd5, 4'd1, 1'b0, 4'd8},  // R8 full rotation
        '{3'b100, 7'd97, 7'd0,  4'd0,  7'd96, 7'd0, 4'd12, 7'd20, 7'd5, 4'd1, 1'b1, 4'd4},  // R4 over limit
        '{3'b100, 7'd16, 7'd0,  4'd3,  7'd96, 7'd0, 4'd12, 7'd20, 7'd5, 4'd1, 1'b1, 4'd4},  // R4 rotation too big
        '{3'b001, 7'd0,  7'd0,  4'd0,  7'd20, 7'd5, 4'd1,  7'd20, 7'd5, 4'd1, 1'b0, 4'd7},  // R7
        '{3'b000, 7'd0,  7'd0,  4'd0,  7'd20, 7'd5, 4'd1,  7'd20, 7'd5, 4'd1, 1'b0, 4'd10}, // R10
        '{3'b011, 7'd0,  7'd0,  4'd0,  7'd20, 7'd5, 4'd1,  7'd20, 7'd5, 4'd1, 1'b1, 4'd9},  // R9
        '{3'b100, 7'd0,  7'd0,  4'd0,  7'd0,  7'd0, 4'd0,  7'd20, 7'd5, 4'd1, 1'b0, 4'd3},  // R3 empty
        '{3'b010, 7'd0,  7'd0,  4'd0,  7'd0,  7'd0, 4'd0,  7'd0,  7'd0, 4'd0, 1'b0, 4'd5}   // R5
    };

    task automatic check(input string what, input int req, input logic [37:0] act, input logic [37:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [6:0] fs, input logic [6:0] ls, input logic [3:0] rs);
        alloc_req = op[2];
        call_req  = op[1];
        ret_req   = op[0];
        alloc_frm = fs;
        alloc_loc = ls;
        alloc_rot = rs;
    endtask

    function automatic logic [37:0] pack(input logic [6:0] fs, input logic [6:0] ls, input logic [3:0] rs);
        return {20'd0, rs, ls, fs};  // R2 layout
    endfunction

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        // R1: state during reset
        repeat (2) @(negedge clk);
        check("cur in reset", 1, cur_marker, '0);
        check("prev in reset", 1, prev_marker, '0);
        check("err in reset", 1, {37'd0, alloc_err}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("cur after reset", 1, cur_marker, '0);

        // Vector table: result due one rising edge after the drive.
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].op, VEC[i].fs, VEC[i].ls, VEC[i].rs);
            @(negedge clk);
            check("cur", int'(VEC[i].req), cur_marker, pack(VEC[i].c_fs, VEC[i].c_ls, VEC[i].c_rs));
            check("prev", int'(VEC[i].req), prev_marker, pack(VEC[i].p_fs, VEC[i].p_ls, VEC[i].p_rs));
            check("err", int'(VEC[i].req), {37'd0, alloc_err}, {37'd0, VEC[i].err});
            check("out count R8", int'(VEC[i].req), {31'd0, out_regs}, {31'd0, VEC[i].c_fs - VEC[i].c_ls});
            check("rot count R8", int'(VEC[i].req), {31'd0, rot_regs}, {31'd0, VEC[i].c_rs, 3'b000});
        end

        // R2: explicit packed value of window 9, locals 3, rotating 1
        drive(3'b100, 7'd9, 7'd3, 4'd1);
        @(negedge clk);
        check("packed layout R2", 2, cur_marker, 38'h0_0000_4189);

        // R3 boundary: locals equal to window accepted
        drive(3'b100, 7'd96, 7'd96, 4'd0);
        @(negedge clk);
        check("locals equal window R3", 3, cur_marker, pack(7'd96, 7'd96, 4'd0));
        check("no error R3", 3, {37'd0, alloc_err}, '0);
        check("zero outputs R8", 8, {31'd0, out_regs}, '0);

        // R6: call from a window with no outputs yields an empty window
        drive(3'b010, 7'd0, 7'd0, 4'd0);
        @(negedge clk);
        check("empty callee R6", 6, cur_marker, '0);
        check("saved caller R5", 5, prev_marker, pack(7'd96, 7'd96, 4'd0));

        // R10: error pulse lasts one cycle only
        drive(3'b100, 7'd5, 7'd6, 4'd0);
        @(negedge clk);
        drive(3'b000, 7'd0, 7'd0, 4'd0);
        check("err raised R4", 4, {37'd0, alloc_err}, 38'd1);
        @(negedge clk);
        check("err cleared R10", 10, {37'd0, alloc_err}, '0);

        // R1: mid-run reset clears both descriptors
        drive(3'b100, 7'd30, 7'd10, 4'd2);
        @(negedge clk);
        drive(3'b010, 7'd0, 7'd0, 4'd0);
        rst_n = 1'b0;
        @(negedge clk);
        drive(3'b000, 7'd0, 7'd0, 4'd0);
        check("cur after mid reset R1", 1, cur_marker, '0);
        check("prev after mid reset R1", 1, prev_marker, '0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule